// File: doc/BRIEF.md
# Corner Marker Overlay Blender

This block sits at the end of a corner-detection video pipeline. It accepts a 24-bit RGB pixel stream, one pixel per clock while the valid strobe is high, together with start-of-frame and end-of-frame marks and a per-pixel corner score from an upstream detector. Each pixel whose score is strictly greater than a programmable threshold is painted with a programmable marker colour, and every other pixel is painted black. The result is the detection image. That image is then mixed with the incoming picture under an 8-bit transparency weight.

The three settings (threshold, marker colour, transparency) are written through a simple write-enable/select/data port into shadow registers. They move into the working registers only when a valid start-of-frame pixel arrives, so a frame is never processed with a mix of old and new settings. A push-button level input can switch any pixel to a corner-only view, and it takes effect on the pixel that is present on the same clock. The pipeline is three registers deep, which keeps each stage short enough for a 148.5 MHz pixel clock.

Top module: `marker_blend_top`

## Requirements
- R1: A pixel presented with pixValid high appears on outRgb exactly 3 clock cycles later. outValid, outSof and outEof carry the same 3-cycle delay, and outSof and outEof are only raised together with outValid.
- R2: A pixel is a corner only when cornerMetric is strictly greater than the working threshold. A score equal to the threshold is not a corner.
- R3: In the detection image a corner pixel takes the working marker colour (bits 23:16 red, 15:8 green, 7:0 blue) and a non-corner pixel is black (0x000000).
- R4: Each 8-bit channel of outRgb equals (orig*a + det*(255-a) + 127)/255, using integer division, where a is the effective transparency. So a=255 passes the input pixel unchanged and a=0 outputs the detection image only.
- R5: While cornerOnly is high, the effective transparency for the pixel on that clock is 0, so the output is the detection image. The input may toggle on any clock.
- R6: A write with cfgWrEn high updates only a shadow register, selected by cfgSel: 0 sets the threshold (cfgData[15:0]), 1 sets the colour (cfgData[23:0]) and 2 sets the transparency (cfgData[7:0]). The shadow values become the working values on a clock where pixSof and pixValid are both high, and they apply to that pixel and to the rest of the frame. A pixSof with pixValid low loads nothing.
- R7: After reset all working and shadow settings are zero, outValid is low and outRgb is zero. Pixels before the first start of frame use threshold 0, colour 0 and transparency 0.
- R8: A clock with pixValid low produces a clock with outValid, outSof and outEof low 3 cycles later.
- R9: A write with cfgSel equal to 3 changes no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Shadow register write strobe |
| cfgSel | input | 2 | Shadow register select |
| cfgData | input | 24 | Shadow register write data |
| pixValid | input | 1 | Input pixel valid |
| pixSof | input | 1 | Input first pixel of frame |
| pixEof | input | 1 | Input last pixel of frame |
| pixRgb | input | 24 | Input pixel, R in 23:16, G in 15:8, B in 7:0 |
| cornerMetric | input | 16 | Corner score for the current pixel |
| cornerOnly | input | 1 | Corner-only view button level |
| outValid | output | 1 | Output pixel valid |
| outSof | output | 1 | Output first pixel of frame |
| outEof | output | 1 | Output last pixel of frame |
| outRgb | output | 24 | Blended output pixel |

## Verification
Every result of this block is due exactly three clocks after its input: blended colour, valid, and frame marks. A setting change written on clock N shows up first on the output of the next valid start-of-frame pixel, three clocks after that pixel. The driver stamps each expected item with the cycle number at which it is due, computed from its own model of the shadow and working settings. The monitor compares only when the cycle counter reaches that stamp, sampling on the falling edge. Idle cycles are also queued, so a spurious outValid or frame mark is caught at the exact cycle where it appears.

// File: rtl/marker_blend_pkg.sv
package marker_blend_pkg;
  localparam int CH_W     = 8;
  localparam int NCH      = 3;
  localparam int PIX_W    = CH_W * NCH;
  localparam int METRIC_W = 16;
  localparam int SEL_W    = 2;
  localparam int SUM_W    = 2 * CH_W + 1;
  localparam int CH_MAX   = (1 << CH_W) - 1;
  localparam int CH_HALF  = CH_MAX / 2;

  localparam logic [SEL_W-1:0] SEL_THRESH = 2'd0;
  localparam logic [SEL_W-1:0] SEL_COLOUR = 2'd1;
  localparam logic [SEL_W-1:0] SEL_ALPHA  = 2'd2;

  typedef struct packed {
    logic [METRIC_W-1:0] thresh;
    logic [PIX_W-1:0]    colour;
    logic [CH_W-1:0]     alpha;
  } cfg_t;

  typedef struct packed {
    logic cornerView;
    cfg_t live;
  } ctrl_t;
endpackage

// File: rtl/marker_blend_ctrl.sv
module marker_blend_ctrl
  import marker_blend_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic [PIX_W-1:0] cfgData,
  input  logic             pixValid,
  input  logic             pixSof,
  input  logic             cornerOnly,
  output ctrl_t            ctrl,
  output cfg_t             shadowCfg,
  output cfg_t             activeCfg
);
  logic frameLoad;
  assign frameLoad = pixValid & pixSof;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowCfg <= '0;
    end else if (cfgWrEn) begin
      case (cfgSel)
        SEL_THRESH: shadowCfg.thresh <= cfgData[METRIC_W-1:0];
        SEL_COLOUR: shadowCfg.colour <= cfgData;
        SEL_ALPHA:  shadowCfg.alpha  <= cfgData[CH_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) activeCfg <= '0;
    else if (frameLoad) activeCfg <= shadowCfg;
  end

  always_comb begin
    ctrl.cornerView = cornerOnly;
    ctrl.live       = frameLoad ? shadowCfg : activeCfg;
  end
endmodule

// File: rtl/marker_blend_dp.sv
module marker_blend_dp
  import marker_blend_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_t               ctrl,
  input  logic                pixValid,
  input  logic                pixSof,
  input  logic                pixEof,
  input  logic [PIX_W-1:0]    pixRgb,
  input  logic [METRIC_W-1:0] cornerMetric,
  output logic                outValid,
  output logic                outSof,
  output logic                outEof,
  output logic [PIX_W-1:0]    outRgb
);
  logic             isCorner;
  logic [PIX_W-1:0] s1Orig, s1Det;
  logic [CH_W-1:0]  s1Alpha;
  logic [2:0]       s1Ctl, s2Ctl, s3Ctl;

  assign isCorner = cornerMetric > ctrl.live.thresh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Orig  <= '0;
      s1Det   <= '0;
      s1Alpha <= '0;
      s1Ctl   <= '0;
      s2Ctl   <= '0;
      s3Ctl   <= '0;
    end else begin
      s1Orig  <= pixRgb;
      s1Det   <= isCorner ? ctrl.live.colour : '0;
      s1Alpha <= ctrl.cornerView ? '0 : ctrl.live.alpha;
      s1Ctl   <= {pixValid, pixSof & pixValid, pixEof & pixValid};
      s2Ctl   <= s1Ctl;
      s3Ctl   <= s2Ctl;
    end
  end

  assign outValid = s3Ctl[2];
  assign outSof   = s3Ctl[1];
  assign outEof   = s3Ctl[0];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [SUM_W-1:0] prodOrig, prodDet, s2Sum, quot;
    logic [CH_W-1:0]  chOut;

    always_comb begin
      prodOrig = SUM_W'(s1Orig[ch*CH_W +: CH_W]) * SUM_W'(s1Alpha);
      prodDet  = SUM_W'(s1Det[ch*CH_W +: CH_W]) * (SUM_W'(CH_MAX) - SUM_W'(s1Alpha));
      quot     = (s2Sum + (s2Sum >> CH_W) + SUM_W'(1)) >> CH_W;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        s2Sum <= '0;
        chOut <= '0;
      end else begin
        s2Sum <= prodOrig + prodDet + SUM_W'(CH_HALF);
        chOut <= (quot > SUM_W'(CH_MAX)) ? CH_W'(CH_MAX) : quot[CH_W-1:0];
      end
    end

    assign outRgb[ch*CH_W +: CH_W] = chOut;
  end
endmodule

// File: rtl/marker_blend_top.sv
module marker_blend_top
  import marker_blend_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [SEL_W-1:0]    cfgSel,
  input  logic [PIX_W-1:0]    cfgData,
  input  logic                pixValid,
  input  logic                pixSof,
  input  logic                pixEof,
  input  logic [PIX_W-1:0]    pixRgb,
  input  logic [METRIC_W-1:0] cornerMetric,
  input  logic                cornerOnly,
  output logic                outValid,
  output logic                outSof,
  output logic                outEof,
  output logic [PIX_W-1:0]    outRgb
);
  ctrl_t ctrl;
  cfg_t  shadowCfg, activeCfg;

  marker_blend_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .pixValid(pixValid), .pixSof(pixSof), .cornerOnly(cornerOnly),
    .ctrl(ctrl), .shadowCfg(shadowCfg), .activeCfg(activeCfg)
  );

  marker_blend_dp uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .pixValid(pixValid), .pixSof(pixSof),
    .pixEof(pixEof), .pixRgb(pixRgb), .cornerMetric(cornerMetric),
    .outValid(outValid), .outSof(outSof), .outEof(outEof), .outRgb(outRgb)
  );
endmodule

// File: rtl/marker_blend_checker.sv
module marker_blend_checker
  import marker_blend_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                pixValid,
  input logic                pixSof,
  input logic                cornerOnly,
  input logic [METRIC_W-1:0] cornerMetric,
  input logic                outValid,
  input logic                outSof,
  input logic [PIX_W-1:0]    outRgb,
  input cfg_t                shadowCfg,
  input cfg_t                activeCfg
);
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R1
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3) |-> (outValid == $past(pixValid, 3)));

  // R1
  sof_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3) |-> (outSof == $past(pixSof && pixValid, 3)));

  // R5
  corner_only_black_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((warm == 2'd3) && $past(pixValid && cornerOnly && (cornerMetric == '0), 3))
      |-> (outRgb == '0));

  // R6
  frame_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixSof) |=> (activeCfg == $past(shadowCfg)));

  // R6
  hold_mid_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pixValid && pixSof) |=> $stable(activeCfg));
endmodule

bind marker_blend_top marker_blend_checker uChk (
  .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixSof(pixSof),
  .cornerOnly(cornerOnly), .cornerMetric(cornerMetric), .outValid(outValid),
  .outSof(outSof), .outRgb(outRgb), .shadowCfg(shadowCfg), .activeCfg(activeCfg)
);

// File: tb/marker_blend_top_tb_top.sv
module marker_blend_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [23:0] cfgData = '0;
  logic        pixValid = 1'b0, pixSof = 1'b0, pixEof = 1'b0, cornerOnly = 1'b0;
  logic [23:0] pixRgb = '0;
  logic [15:0] cornerMetric = '0;
  logic        outValid, outSof, outEof;
  logic [23:0] outRgb;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic done = 1'b0;

  typedef struct {
    logic        v, s, e;
    logic [23:0] rgb;
    int          due;
    string       tag;
  } item_t;
  item_t expQ[$];

  logic [15:0] mShThr = '0, mAcThr = '0;
  logic [23:0] mShCol = '0, mAcCol = '0;
  logic [7:0]  mShA = '0, mAcA = '0;

  marker_blend_top dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .pixValid(pixValid), .pixSof(pixSof), .pixEof(pixEof), .pixRgb(pixRgb),
    .cornerMetric(cornerMetric), .cornerOnly(cornerOnly), .outValid(outValid),
    .outSof(outSof), .outEof(outEof), .outRgb(outRgb)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] mix(input int o, input int d, input int a);
    int r;
    r = (o * a + d * (255 - a) + 127) / 255;
    return (r > 255) ? 8'd255 : 8'(r);
  endfunction

  task automatic check(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic tick(input logic v, input logic s, input logic e, input logic [23:0] rgb,
                      input logic [15:0] met, input logic co, input logic wr,
                      input logic [1:0] sel, input logic [23:0] data, input string tag);
    item_t it;
    logic [23:0] det;
    int a;
    pixValid = v; pixSof = s; pixEof = e; pixRgb = rgb; cornerMetric = met;
    cornerOnly = co; cfgWrEn = wr; cfgSel = sel; cfgData = data;
    if (v && s) begin
      mAcThr = mShThr; mAcCol = mShCol; mAcA = mShA;
    end
    det = (met > mAcThr) ? mAcCol : 24'h0;
    a = co ? 0 : int'(mAcA);
    it.v = v; it.s = v && s; it.e = v && e; it.tag = tag; it.due = cyc + 3;
    it.rgb = {mix(rgb[23:16], det[23:16], a), mix(rgb[15:8], det[15:8], a), mix(rgb[7:0], det[7:0], a)};
    expQ.push_back(it);
    if (wr) begin
      case (sel)
        2'd0: mShThr = data[15:0];
        2'd1: mShCol = data;
        2'd2: mShA = data[7:0];
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic pix(input logic [23:0] rgb, input logic [15:0] met, input logic s,
                     input logic e, input logic co, input string tag);
    tick(1'b1, s, e, rgb, met, co, 1'b0, 2'd0, 24'h0, tag);
  endtask

  task automatic idle(input string tag);
    tick(1'b0, 1'b0, 1'b0, 24'h0, 16'h0, 1'b0, 1'b0, 2'd0, 24'h0, tag);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [23:0] data, input string tag);
    tick(1'b0, 1'b0, 1'b0, 24'h0, 16'h0, 1'b0, 1'b1, sel, data, tag);
  endtask

  // monitor: compare each queued item at its due cycle
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].due == cyc) begin
      item_t it;
      it = expQ.pop_front();
      check({it.tag, "/R1 valid"}, outValid === it.v, 32'(outValid), 32'(it.v));
      check({it.tag, "/R1 sof"}, outSof === it.s, 32'(outSof), 32'(it.s));
      check({it.tag, "/R1 eof"}, outEof === it.e, 32'(outEof), 32'(it.e));
      if (it.v) check(it.tag, outRgb === it.rgb, 32'(outRgb), 32'(it.rgb));
    end
  end

  initial begin : watchdog
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] seed;
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 reset valid", outValid === 1'b0, 32'(outValid), 32'd0);
    check("R7 reset rgb", outRgb === 24'h0, 32'(outRgb), 32'd0);
    rstN = 1'b1;
    // R7: zero settings before first frame start
    pix(24'h123456, 16'd5, 1'b0, 1'b0, 1'b0, "R7");
    pix(24'hABCDEF, 16'd0, 1'b0, 1'b0, 1'b0, "R7");
    // R6: shadow writes do not take effect mid-frame
    wr(2'd0, 24'd100, "R6");
    wr(2'd1, 24'hFF8000, "R6");
    wr(2'd2, 24'd128, "R6");
    pix(24'h406080, 16'd200, 1'b0, 1'b0, 1'b0, "R6");
    // R2/R3/R4: new frame loads settings on its first pixel
    pix(24'h406080, 16'd101, 1'b1, 1'b0, 1'b0, "R2");
    pix(24'h406080, 16'd100, 1'b0, 1'b0, 1'b0, "R2");
    pix(24'hFFFFFF, 16'd99, 1'b0, 1'b0, 1'b0, "R3");
    pix(24'h000000, 16'd5000, 1'b0, 1'b0, 1'b0, "R3");
    idle("R8");
    pix(24'h7F7F7F, 16'd300, 1'b0, 1'b1, 1'b0, "R4");
    // R4: alpha 255 passes the original
    wr(2'd2, 24'd255, "R4");
    pix(24'h0A0B0C, 16'd900, 1'b1, 1'b0, 1'b0, "R4");
    pix(24'hFEDCBA, 16'd10, 1'b0, 1'b1, 1'b0, "R4");
    // R4: alpha 0 gives detection image only
    wr(2'd2, 24'd0, "R4");
    wr(2'd1, 24'h00FF00, "R3");
    pix(24'hFFFFFF, 16'd900, 1'b1, 1'b0, 1'b0, "R4");
    pix(24'hFFFFFF, 16'd1, 1'b0, 1'b1, 1'b0, "R4");
    // R5: corner-only toggling per pixel
    wr(2'd2, 24'd200, "R5");
    pix(24'h336699, 16'd500, 1'b1, 1'b0, 1'b1, "R5");
    pix(24'h336699, 16'd500, 1'b0, 1'b0, 1'b0, "R5");
    pix(24'h336699, 16'd20, 1'b0, 1'b0, 1'b1, "R5");
    pix(24'h336699, 16'd20, 1'b0, 1'b1, 1'b0, "R5");
    // R6: frame start with valid low loads nothing
    wr(2'd2, 24'd10, "R6");
    tick(1'b0, 1'b1, 1'b0, 24'h0, 16'h0, 1'b0, 1'b0, 2'd0, 24'h0, "R8");
    pix(24'hC0C0C0, 16'd500, 1'b0, 1'b0, 1'b0, "R6");
    pix(24'hC0C0C0, 16'd500, 1'b1, 1'b0, 1'b0, "R6");
    // R9: select 3 ignored
    wr(2'd3, 24'hFFFFFF, "R9");
    pix(24'h102030, 16'd500, 1'b1, 1'b0, 1'b0, "R9");
    pix(24'h102030, 16'd50, 1'b0, 1'b1, 1'b0, "R9");
    // R4/R1: pseudo-random stream
    seed = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      if (i % 37 == 5) wr(2'(seed[9:8] % 3), seed[31:8], "R6");
      else if (seed[3:0] == 4'd0) idle("R8");
      else pix(seed[31:8], {8'h0, seed[17:10]}, (i % 50) == 0, (i % 50) == 49, seed[4] & seed[5], "R4");
    end
    repeat (6) idle("R8");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule